// File: doc/BRIEF.md
# Capture Buffer Dual-Port Readout

This block drains stored 8-bit samples from a capture memory into the read-clock domain. It presents them on one or two parallel output ports. One configuration bit selects the mode. In single-port mode every enabled read cycle puts the next sample on port 1, and port 2 is released to high impedance. In dual-port mode every enabled read cycle delivers a pair of consecutive samples: port 2 carries the earlier sample and port 1 the later one.

The block owns the read pointer and drives the memory read address. The memory is assumed to return, combinationally, the sample at that address on `mem_rdata0` and the sample at the following address (modulo the depth) on `mem_rdata1`. Each port has a ready line that toggles whenever its word changes. A receiver can therefore capture on either edge of that line without knowing the clock-to-data delay. While read enable is low, both ports hold their words and both ready lines keep their levels.

A mode change written through the configuration interface waits for the next enabled read. On that read the pointer is forced down to an even address before the pair is fetched.

Top module: `capbuf_readout`

## Requirements
- R1: A synchronous reset (`rst_rd` high at a clock edge) sets both data ports to zero. It also sets both ready lines low, `p2_oe` low, the read pointer to 0 and the pending mode to single-port.
- R2: A configuration write (`cfg_we` high) to address 0xF loads the pending mode from `cfg_wdata` bit 12: 1 selects dual-port and 0 selects single-port. Writes to any other address leave the mode unchanged.
- R3: In single-port mode each cycle with `rd_en` high loads `p1_data` with the sample at the current pointer and advances the pointer by one.
- R4: In dual-port mode each cycle with `rd_en` high loads `p2_data` with the sample at the current (even) pointer and `p1_data` with the sample one address later. The pointer then advances by two.
- R5: `p2_oe` is 1 while the active mode is dual-port and 0 while it is single-port. `p1_oe` is always 1.
- R6: In a cycle with `rd_en` low, both data ports keep their previous values. In single-port mode reads, `p2_data` is also left unchanged.
- R7: `p1_rdy` inverts on every enabled read. `p2_rdy` inverts on every enabled dual-port read. Neither ready line changes in any other cycle.
- R8: A mode written per R2 has no effect until the next cycle with `rd_en` high. That read uses the new mode, and the pointer's bit 0 is cleared first. A read in the same cycle as the write still uses the old mode.
- R9: The read pointer wraps from DEPTH-1 to 0, where DEPTH is a power-of-two parameter (default 16).
- R10: `mem_raddr` shows, before the clock edge, the address of the sample that the next enabled read will place on port 1 (single-port mode) or on port 2 (dual-port mode), including any realignment from R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rd | input | 1 | Read clock |
| rst_rd | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Read enable, one word per cycle while high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| mem_raddr | output | $clog2(DEPTH) | Capture memory read address |
| mem_rdata0 | input | 8 | Sample at `mem_raddr` |
| mem_rdata1 | input | 8 | Sample at `mem_raddr`+1 modulo DEPTH |
| p1_data | output | 8 | Port 1 data (later sample in dual-port mode) |
| p1_oe | output | 1 | Port 1 output enable |
| p1_rdy | output | 1 | Port 1 data-ready toggle |
| p2_data | output | 8 | Port 2 data (earlier sample in dual-port mode) |
| p2_oe | output | 1 | Port 2 output enable (0 = high impedance) |
| p2_rdy | output | 1 | Port 2 data-ready toggle |

## Verification
The hardest case to reach from the ports is a switch into dual-port mode while the pointer sits on an odd address, combined with a configuration write that lands in the same cycle as a read. The stimulus first performs an odd number of single-port reads. It then writes the mode with read enable low, idles, and reads: this is where the realignment and the expected address are visible. Later, a write and a read in the same cycle show that the old mode is still used. A pattern of interleaved reads, idles and mode writes then crosses the wrap point in both modes.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;
    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_DUAL   = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/capbuf_cfg.sv
module capbuf_cfg
    import capbuf_pkg::*;
#(
    parameter int                CFG_AW        = 4,
    parameter int                CFG_DW        = 16,
    parameter logic [CFG_AW-1:0] MODE_REG_ADDR = 'hF,
    parameter int                DUAL_BIT      = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  logic [CFG_DW-1:0] wdata,
    output rd_mode_e          pend_mode
);
    typedef struct packed {
        rd_mode_e pend;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && addr == MODE_REG_ADDR) begin
            st_d.pend = rd_mode_e'(wdata[DUAL_BIT]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{pend: MODE_SINGLE};
        else     st_q <= st_d;
    end

    assign pend_mode = st_q.pend;
endmodule

// File: rtl/capbuf_seq.sv
module capbuf_seq
    import capbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  rd_mode_e      pend_mode,
    output logic [AW-1:0] raddr,
    output rd_mode_e      mode_q
);
    localparam logic [AW-1:0] STEP_ONE = AW'(1);
    localparam logic [AW-1:0] STEP_TWO = AW'(2);

    typedef struct packed {
        logic [AW-1:0] ptr;
        rd_mode_e      mode;
    } seq_state_t;

    seq_state_t    st_d, st_q;
    logic          realign;
    logic [AW-1:0] base;

    always_comb begin
        st_d    = st_q;
        realign = (pend_mode != st_q.mode);
        base    = realign ? {st_q.ptr[AW-1:1], 1'b0} : st_q.ptr;
        if (rd_en) begin
            st_d.mode = pend_mode;
            st_d.ptr  = base + ((pend_mode == MODE_DUAL) ? STEP_TWO : STEP_ONE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{ptr: '0, mode: MODE_SINGLE};
        else     st_q <= st_d;
    end

    assign raddr  = base;
    assign mode_q = st_q.mode;
endmodule

// File: rtl/capbuf_port.sv
module capbuf_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         rdy
);
    typedef struct packed {
        logic [W-1:0] data;
        logic         rdy;
    } port_state_t;

    port_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.data = din;
            st_d.rdy  = ~st_q.rdy;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{data: '0, rdy: 1'b0};
        else     st_q <= st_d;
    end

    assign dout = st_q.data;
    assign rdy  = st_q.rdy;
endmodule

// File: rtl/capbuf_readout.sv
module capbuf_readout
    import capbuf_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int DEPTH    = 16,
    parameter int CFG_AW   = 4,
    parameter int CFG_DW   = 16,
    parameter int DUAL_BIT = 12,
    parameter int AW       = $clog2(DEPTH)
) (
    input  logic                clk_rd,
    input  logic                rst_rd,
    input  logic                rd_en,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [CFG_DW-1:0]   cfg_wdata,
    output logic [AW-1:0]       mem_raddr,
    input  logic [SAMPLE_W-1:0] mem_rdata0,
    input  logic [SAMPLE_W-1:0] mem_rdata1,
    output logic [SAMPLE_W-1:0] p1_data,
    output logic                p1_oe,
    output logic                p1_rdy,
    output logic [SAMPLE_W-1:0] p2_data,
    output logic                p2_oe,
    output logic                p2_rdy
);
    localparam int                NPORT         = 2;
    localparam logic [CFG_AW-1:0] MODE_REG_ADDR = CFG_AW'(15);

    rd_mode_e dual_pend;
    rd_mode_e mode_q;

    logic [NPORT-1:0]               port_load;
    logic [NPORT-1:0][SAMPLE_W-1:0] port_din;
    logic [NPORT-1:0][SAMPLE_W-1:0] port_dout;
    logic [NPORT-1:0]               port_rdy;

    capbuf_cfg #(
        .CFG_AW       (CFG_AW),
        .CFG_DW       (CFG_DW),
        .MODE_REG_ADDR(MODE_REG_ADDR),
        .DUAL_BIT     (DUAL_BIT)
    ) u_cfg (
        .clk      (clk_rd),
        .rst      (rst_rd),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .pend_mode(dual_pend)
    );

    capbuf_seq #(
        .DEPTH(DEPTH),
        .AW   (AW)
    ) u_seq (
        .clk      (clk_rd),
        .rst      (rst_rd),
        .rd_en    (rd_en),
        .pend_mode(dual_pend),
        .raddr    (mem_raddr),
        .mode_q   (mode_q)
    );

    // index 0 = port 1 (later / only sample), index 1 = port 2 (earlier sample)
    always_comb begin
        port_load[0] = rd_en;
        port_load[1] = rd_en && (dual_pend == MODE_DUAL);
        port_din[0]  = (dual_pend == MODE_DUAL) ? mem_rdata1 : mem_rdata0;
        port_din[1]  = mem_rdata0;
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        capbuf_port #(
            .W(SAMPLE_W)
        ) u_port (
            .clk (clk_rd),
            .rst (rst_rd),
            .load(port_load[g]),
            .din (port_din[g]),
            .dout(port_dout[g]),
            .rdy (port_rdy[g])
        );
    end

    assign p1_data = port_dout[0];
    assign p1_rdy  = port_rdy[0];
    assign p1_oe   = 1'b1;
    assign p2_data = port_dout[1];
    assign p2_rdy  = port_rdy[1];
    assign p2_oe   = (mode_q == MODE_DUAL);
endmodule

// File: rtl/capbuf_readout_chk.sv
module capbuf_readout_chk #(
    parameter int SAMPLE_W = 8,
    parameter int AW       = 4
) (
    input logic                clk_rd,
    input logic                rst_rd,
    input logic                rd_en,
    input logic                dual_pend,
    input logic [AW-1:0]       mem_raddr,
    input logic [SAMPLE_W-1:0] p1_data,
    input logic                p1_rdy,
    input logic [SAMPLE_W-1:0] p2_data,
    input logic                p2_oe,
    input logic                p2_rdy
);
    // R1
    reset_state_chk: assert property (@(posedge clk_rd) disable iff (rst_rd)
        $fell(rst_rd) |-> (p1_data == '0 && p2_data == '0 && !p1_rdy && !p2_rdy && !p2_oe));

    // R6
    idle_hold_chk: assert property (@(posedge clk_rd) disable iff (rst_rd)
        !rd_en |=> ($stable(p1_data) && $stable(p2_data)));

    // R7
    idle_rdy_chk: assert property (@(posedge clk_rd) disable iff (rst_rd)
        !rd_en |=> ($stable(p1_rdy) && $stable(p2_rdy)));

    // R7
    p1_toggle_chk: assert property (@(posedge clk_rd) disable iff (rst_rd)
        rd_en |=> (p1_rdy != $past(p1_rdy)));

    // R7
    single_p2_quiet_chk: assert property (@(posedge clk_rd) disable iff (rst_rd)
        (rd_en && !dual_pend) |=> ($stable(p2_rdy) && $stable(p2_data)));

    // R5
    oe_mode_chk: assert property (@(posedge clk_rd) disable iff (rst_rd)
        rd_en |=> (p2_oe == $past(dual_pend)));

    // R8
    oe_wait_chk: assert property (@(posedge clk_rd) disable iff (rst_rd)
        !rd_en |=> $stable(p2_oe));

    // R8
    even_pair_chk: assert property (@(posedge clk_rd) disable iff (rst_rd)
        (rd_en && dual_pend) |-> !mem_raddr[0]);
endmodule

bind capbuf_readout capbuf_readout_chk #(
    .SAMPLE_W(SAMPLE_W),
    .AW      (AW)
) u_chk (
    .clk_rd   (clk_rd),
    .rst_rd   (rst_rd),
    .rd_en    (rd_en),
    .dual_pend(dual_pend),
    .mem_raddr(mem_raddr),
    .p1_data  (p1_data),
    .p1_rdy   (p1_rdy),
    .p2_data  (p2_data),
    .p2_oe    (p2_oe),
    .p2_rdy   (p2_rdy)
);

// File: tb/capbuf_readout_tb.sv
`timescale 1ns/1ps
module capbuf_readout_tb;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);

    logic          clk_rd = 1'b0;
    logic          rst_rd = 1'b1;
    logic          rd_en = 1'b0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_addr = '0;
    logic [15:0]   cfg_wdata = '0;
    logic [AW-1:0] mem_raddr;
    logic [7:0]    mem_rdata0, mem_rdata1;
    logic [7:0]    p1_data, p2_data;
    logic          p1_oe, p1_rdy, p2_oe, p2_rdy;

    logic [7:0] mem_img [DEPTH];
    logic [AW-1:0] raddr_next;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 0;

    // reference model state
    int   m_ptr, m_mode, m_pend;
    logic [7:0] m_p1, m_p2;
    bit   m_r1, m_r2;

    always #4 clk_rd = ~clk_rd;

    assign raddr_next = mem_raddr + 1'b1;
    assign mem_rdata0 = mem_img[mem_raddr];
    assign mem_rdata1 = mem_img[raddr_next];

    capbuf_readout u_dut (
        .clk_rd(clk_rd), .rst_rd(rst_rd), .rd_en(rd_en),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .mem_raddr(mem_raddr), .mem_rdata0(mem_rdata0), .mem_rdata1(mem_rdata1),
        .p1_data(p1_data), .p1_oe(p1_oe), .p1_rdy(p1_rdy),
        .p2_data(p2_data), .p2_oe(p2_oe), .p2_rdy(p2_rdy)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int exp_addr();
        return (m_pend != m_mode) ? (m_ptr & ~1) : m_ptr;
    endfunction

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input bit rst, input bit rd, input bit we,
                        input logic [3:0] a, input logic [15:0] d);
        string dtag;
        rst_rd = rst; rd_en = rd; cfg_we = we; cfg_addr = a; cfg_wdata = d;
        #1;
        if (!rst) check("R10", "mem_raddr", int'(mem_raddr), exp_addr());
        @(posedge clk_rd);
        #1;
        if (rst) begin
            m_ptr = 0; m_mode = 0; m_pend = 0;
            m_p1 = '0; m_p2 = '0; m_r1 = 0; m_r2 = 0;
        end else begin
            if (rd) begin
                m_ptr  = exp_addr();
                m_mode = m_pend;
                if (m_mode == 1) begin
                    m_p2 = mem_img[m_ptr];
                    m_p1 = mem_img[(m_ptr + 1) % DEPTH];
                    m_ptr = (m_ptr + 2) % DEPTH;
                    m_r1 = !m_r1; m_r2 = !m_r2;
                end else begin
                    m_p1 = mem_img[m_ptr];
                    m_ptr = (m_ptr + 1) % DEPTH;
                    m_r1 = !m_r1;
                end
            end
            if (we && a == 4'hF) m_pend = int'(d[12]);
        end
        @(negedge clk_rd);
        dtag = rst ? "R1" : (!rd ? "R6" : (m_mode == 1 ? "R4" : "R3"));
        check(dtag, "p1_data", int'(p1_data), int'(m_p1));
        check(dtag, "p2_data", int'(p2_data), int'(m_p2));
        check(rst ? "R1" : "R7", "p1_rdy", int'(p1_rdy), int'(m_r1));
        check(rst ? "R1" : "R7", "p2_rdy", int'(p2_rdy), int'(m_r2));
        check(rst ? "R1" : "R5", "p2_oe", int'(p2_oe), m_mode);
        check("R5", "p1_oe", int'(p1_oe), 1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk_rd);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog run did not complete actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem_img[i] = 8'(8'h31 + i * 7);
        @(negedge clk_rd);
        // R1: reset state
        step(1, 0, 0, 4'h0, 16'h0);
        step(1, 0, 0, 4'h0, 16'h0);
        // R3: single-port reads
        repeat (5) step(0, 1, 0, 4'h0, 16'h0);
        // R6: idle holds
        repeat (3) step(0, 0, 0, 4'h0, 16'h0);
        // R9: continue through the wrap
        repeat (12) step(0, 1, 0, 4'h0, 16'h0);
        check("R9", "p1 after wrap", int'(p1_data), int'(mem_img[0]));
        // R2: write to a different address is ignored
        step(0, 0, 1, 4'h3, 16'h1000);
        step(0, 0, 1, 4'hF, 16'hEFFF);
        step(0, 1, 0, 4'h0, 16'h0);
        check("R2", "p2_oe after foreign write", int'(p2_oe), 0);
        step(0, 1, 0, 4'h0, 16'h0);   // pointer now odd (3)
        // R8: write dual mode, no read yet
        step(0, 0, 1, 4'hF, 16'h1000);
        check("R8", "p2_oe before read", int'(p2_oe), 0);
        step(0, 0, 0, 4'h0, 16'h0);
        step(0, 1, 0, 4'h0, 16'h0);   // realigned to address 2
        check("R8", "p2 realigned sample", int'(p2_data), int'(mem_img[2]));
        check("R4", "p1 later sample", int'(p1_data), int'(mem_img[3]));
        // R4, R9: dual reads across the wrap
        repeat (9) step(0, 1, 0, 4'h0, 16'h0);
        repeat (2) step(0, 0, 0, 4'h0, 16'h0);
        // R8: write single with a read in the same cycle, read stays dual
        step(0, 1, 1, 4'hF, 16'h0000);
        check("R8", "p2_oe same-cycle write", int'(p2_oe), 1);
        step(0, 1, 0, 4'h0, 16'h0);
        check("R5", "p2_oe single", int'(p2_oe), 0);
        repeat (4) step(0, 1, 0, 4'h0, 16'h0);
        // R1: reset in mid-run
        step(1, 1, 1, 4'hF, 16'h1000);
        repeat (3) step(0, 1, 0, 4'h0, 16'h0);
        // mixed pattern of reads, idles and mode writes
        for (int i = 0; i < 60; i++) begin
            step(0, (i % 3) != 0, (i % 11) == 5, 4'hF,
                 ((i / 11) % 2 == 0) ? 16'h1000 : 16'h0000);
        end
        finish_run();
    end
endmodule